// File: doc/BRIEF.md
# UART DMA Ready Signal Generator

This block drives the two active-low handshake lines that a DMA controller watches on a FIFO UART: a receive-ready line that asks for reads and a transmit-ready line that asks for writes. It is placed beside the receive and transmit FIFOs. As inputs it takes their occupancy counts, the holding-register full flags used when FIFOs are off, the receive trigger threshold, the receive timeout event and the transmit-full flag.

A 4-bit FIFO control write port selects between two handshake modes and can issue FIFO clears. Bit 0 enables the FIFOs and bit 3 selects multi-transfer operation. Multi-transfer (burst) mode is active only when both bits are set. Every other combination gives single-transfer mode. A write with bit 1 set clears the receive side, and a write with bit 2 set clears the transmit side. The mode bits are latched on the write and take effect from the following cycle.

Each direction is a small state machine with three states:
- `OFF`: the line is high.
- `SINGLE`: the line is low under single-transfer rules.
- `BURST`: the line is low and latched under multi-transfer rules.

Receive transitions:
- OFF→SINGLE: data is present.
- SINGLE→OFF: no data remains.
- OFF→BURST: the trigger level is reached or a timeout occurs.
- BURST→OFF: the FIFO is empty.
- SINGLE→BURST: the mode changes while data is present.

Transmit transitions:
- OFF→SINGLE: the FIFO or holding register is empty.
- SINGLE→OFF: a character is loaded.
- OFF→BURST: the FIFO is empty.
- BURST→OFF: the FIFO is full.
- SINGLE→BURST: the mode changes while the FIFO is not full.

A clear forces the receive machine to OFF and the transmit machine to SINGLE.

Top module: `uart_dma_ready`

## Requirements
- R1: While reset is asserted, both `rx_ready_n` and `tx_ready_n` are high. After reset the mode register holds FIFO-off, single-transfer.
- R2: A write on `ctrl_wr` latches `ctrl_data[0]` (FIFO enable) and `ctrl_data[3]` (burst select). These take effect from the next cycle. Burst mode applies only when both latched bits are 1. With bit 3 set and bit 0 clear the block behaves in single-transfer mode.
- R3: In single-transfer mode, `rx_ready_n` follows one cycle after the data-present condition. It is low when that condition is true and high when it is false. With FIFOs enabled the condition is `rx_count != 0`. With FIFOs disabled it is `rx_hold_full`.
- R4: In burst mode, an inactive `rx_ready_n` goes low one cycle after a cycle in which `rx_count != 0` and either `rx_count >= rx_trigger` or `rx_timeout` is 1. While `rx_count` is below the trigger and no timeout occurs, it stays high.
- R5: In burst mode, once `rx_ready_n` is low it stays low while `rx_count != 0`. It goes high one cycle after a cycle with `rx_count == 0`.
- R6: In single-transfer mode, `tx_ready_n` is low one cycle after an empty condition and high one cycle after a non-empty condition. With FIFOs enabled, empty means `tx_count == 0`. With FIFOs disabled, empty means `tx_hold_full == 0`.
- R7: In burst mode, an inactive `tx_ready_n` goes low one cycle after `tx_count == 0`. Once low, it stays low until a cycle with `tx_full == 1`, and goes high in the cycle after that.
- R8: A control write with `ctrl_data[1] = 1` forces `rx_ready_n` high in the next cycle, whatever the counts and the mode.
- R9: A control write with `ctrl_data[2] = 1` forces `tx_ready_n` low in the next cycle, whatever the counts and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | FIFO control write strobe |
| ctrl_data | input | 4 | Control bits: 0 FIFO enable, 1 receive clear, 2 transmit clear, 3 burst select |
| rx_count | input | CW | Receive FIFO occupancy |
| rx_hold_full | input | 1 | Receive holding register full (FIFOs off) |
| rx_trigger | input | CW | Receive trigger threshold |
| rx_timeout | input | 1 | Receive timeout event |
| tx_count | input | CW | Transmit FIFO occupancy |
| tx_hold_full | input | 1 | Transmit holding register full (FIFOs off) |
| tx_full | input | 1 | Transmit FIFO completely full |
| rx_ready_n | output | 1 | Receive DMA request, active low |
| tx_ready_n | output | 1 | Transmit DMA request, active low |

## Verification
Every combination of the two mode bits is swept together with several trigger thresholds, with and without a timeout pulse. In each sweep the receive count ramps from empty to full and back, while the transmit count ramps from full to empty and back.

The ramps separate the two modes. A single-transfer output tracks the instantaneous count. A burst output must assert at the threshold, or at the timeout, and then hold through the partial counts until the release point. The case with bit 3 set and bit 0 clear confirms that the select bit alone does not enter burst mode.

Passes with FIFOs disabled toggle the holding-register flags. Clear writes placed mid-ramp check that the forced values override both modes.

// File: rtl/uart_dma_ready_pkg.sv
package uart_dma_ready_pkg;

    // bit positions inside the control write word (behavioural)
    localparam int unsigned CTRL_FEN_BIT = 0;
    localparam int unsigned CTRL_RXCLR_BIT = 1;
    localparam int unsigned CTRL_TXCLR_BIT = 2;
    localparam int unsigned CTRL_BURST_BIT = 3;
    localparam int unsigned CTRL_W = 4;

    typedef enum logic [1:0] {
        RX_OFF    = 2'd0,
        RX_SINGLE = 2'd1,
        RX_BURST  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_OFF    = 2'd0,
        TX_SINGLE = 2'd1,
        TX_BURST  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/dmardy_mode_reg.sv
module dmardy_mode_reg
    import uart_dma_ready_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic [CW-1:0]     rx_count,
    input  logic              rx_hold_full,
    input  logic [CW-1:0]     rx_trigger,
    input  logic              rx_timeout,
    input  logic [CW-1:0]     tx_count,
    input  logic              tx_hold_full,
    output logic              burst_mode,
    output logic              rx_clear,
    output logic              tx_clear,
    output logic              rx_have,
    output logic              rx_hit,
    output logic              rx_empty,
    output logic              tx_empty,
    output logic              tx_fifo_empty
);

    logic fifo_en_q;
    logic burst_sel_q;

    // latched mode bits; clears act on the write cycle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en_q   <= 1'b0;
            burst_sel_q <= 1'b0;
        end else if (ctrl_wr) begin
            fifo_en_q   <= ctrl_data[CTRL_FEN_BIT];
            burst_sel_q <= ctrl_data[CTRL_BURST_BIT];
        end
    end

    logic rx_nonzero;
    logic rx_at_level;

    always_comb begin
        burst_mode    = fifo_en_q & burst_sel_q;
        rx_clear      = ctrl_wr & ctrl_data[CTRL_RXCLR_BIT];
        tx_clear      = ctrl_wr & ctrl_data[CTRL_TXCLR_BIT];
        rx_nonzero    = (rx_count != '0);
        rx_at_level   = (rx_count >= rx_trigger);
        rx_have       = fifo_en_q ? rx_nonzero : rx_hold_full;
        rx_hit        = rx_nonzero & (rx_at_level | rx_timeout);
        rx_empty      = ~rx_nonzero;
        tx_fifo_empty = (tx_count == '0);
        tx_empty      = fifo_en_q ? tx_fifo_empty : ~tx_hold_full;
    end

endmodule

// File: rtl/dmardy_rx_fsm.sv
module dmardy_rx_fsm
    import uart_dma_ready_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic rx_clear,
    input  logic rx_have,
    input  logic rx_hit,
    input  logic rx_empty,
    output logic rx_ready_n
);

    rx_state_e state_q;
    rx_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (rx_clear) begin
            state_d = RX_OFF;
        end else if (!burst_mode) begin
            state_d = rx_have ? RX_SINGLE : RX_OFF;
        end else begin
            unique case (state_q)
                RX_OFF:    state_d = rx_hit ? RX_BURST : RX_OFF;
                RX_SINGLE: state_d = rx_empty ? RX_OFF : RX_BURST;
                RX_BURST:  state_d = rx_empty ? RX_OFF : RX_BURST;
                default:   state_d = RX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RX_SINGLE, RX_BURST: rx_ready_n = 1'b0;
            default:             rx_ready_n = 1'b1;
        endcase
    end

    // R8: a receive clear always drops the request
    p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> rx_ready_n);

    // R5: burst request holds while data remains
    p_rx_burst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && !rx_ready_n && !rx_empty && !rx_clear) |=> !rx_ready_n);

    // R3: single-transfer request tracks data presence one cycle later
    p_rx_single_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_mode && !rx_clear) |=> (rx_ready_n == !$past(rx_have)));

    // R4: below threshold without timeout an idle request stays idle
    p_rx_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && rx_ready_n && !rx_hit) |=> rx_ready_n);

endmodule

// File: rtl/dmardy_tx_fsm.sv
module dmardy_tx_fsm
    import uart_dma_ready_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic tx_clear,
    input  logic tx_empty,
    input  logic tx_fifo_empty,
    input  logic tx_full,
    output logic tx_ready_n
);

    tx_state_e state_q;
    tx_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (tx_clear) begin
            state_d = TX_SINGLE;
        end else if (!burst_mode) begin
            state_d = tx_empty ? TX_SINGLE : TX_OFF;
        end else begin
            unique case (state_q)
                TX_OFF:    state_d = tx_fifo_empty ? TX_BURST : TX_OFF;
                TX_SINGLE: state_d = tx_full ? TX_OFF : TX_BURST;
                TX_BURST:  state_d = tx_full ? TX_OFF : TX_BURST;
                default:   state_d = TX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TX_SINGLE, TX_BURST: tx_ready_n = 1'b0;
            default:             tx_ready_n = 1'b1;
        endcase
    end

    // R9: a transmit clear always raises the request
    p_tx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clear |=> !tx_ready_n);

    // R7: burst request holds until full
    p_tx_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && !tx_ready_n && !tx_full && !tx_clear) |=> !tx_ready_n);

    // R7: once released, no request until the FIFO drains
    p_tx_burst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && tx_ready_n && !tx_fifo_empty && !tx_clear) |=> tx_ready_n);

    // R6: single-transfer request tracks emptiness one cycle later
    p_tx_single_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_mode && !tx_clear) |=> (tx_ready_n == !$past(tx_empty)));

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_dma_ready_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    input  logic [CW-1:0]     rx_count,
    input  logic              rx_hold_full,
    input  logic [CW-1:0]     rx_trigger,
    input  logic              rx_timeout,
    input  logic [CW-1:0]     tx_count,
    input  logic              tx_hold_full,
    input  logic              tx_full,
    output logic              rx_ready_n,
    output logic              tx_ready_n
);

    logic burst_mode;
    logic rx_clear;
    logic tx_clear;
    logic rx_have;
    logic rx_hit;
    logic rx_empty;
    logic tx_empty;
    logic tx_fifo_empty;

    dmardy_mode_reg #(.CW(CW)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_data    (ctrl_data),
        .rx_count     (rx_count),
        .rx_hold_full (rx_hold_full),
        .rx_trigger   (rx_trigger),
        .rx_timeout   (rx_timeout),
        .tx_count     (tx_count),
        .tx_hold_full (tx_hold_full),
        .burst_mode   (burst_mode),
        .rx_clear     (rx_clear),
        .tx_clear     (tx_clear),
        .rx_have      (rx_have),
        .rx_hit       (rx_hit),
        .rx_empty     (rx_empty),
        .tx_empty     (tx_empty),
        .tx_fifo_empty(tx_fifo_empty)
    );

    dmardy_rx_fsm u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_mode (burst_mode),
        .rx_clear   (rx_clear),
        .rx_have    (rx_have),
        .rx_hit     (rx_hit),
        .rx_empty   (rx_empty),
        .rx_ready_n (rx_ready_n)
    );

    dmardy_tx_fsm u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode   (burst_mode),
        .tx_clear     (tx_clear),
        .tx_empty     (tx_empty),
        .tx_fifo_empty(tx_fifo_empty),
        .tx_full      (tx_full),
        .tx_ready_n   (tx_ready_n)
    );

    // R1: both requests idle while held in reset
    always_comb begin
        if (!rst_n) begin
            a_reset_idle_r1: assert (rx_ready_n && tx_ready_n);
        end
    end

endmodule

// File: tb/tb_uart_dma_ready.sv
`timescale 1ns/1ps
module tb_uart_dma_ready;

    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [3:0]    ctrl_data = '0;
    logic [CW-1:0] rx_count = '0;
    logic          rx_hold_full = 1'b0;
    logic [CW-1:0] rx_trigger = CW'(1);
    logic          rx_timeout = 1'b0;
    logic [CW-1:0] tx_count = '0;
    logic          tx_hold_full = 1'b0;
    logic          tx_full = 1'b0;
    logic          rx_ready_n;
    logic          tx_ready_n;

    int total = 0;
    int bad = 0;

    // bench model state
    logic m_fen = 1'b0;
    logic m_sel = 1'b0;
    logic e_rx = 1'b1;
    logic e_tx = 1'b1;

    always #4 clk = ~clk;

    uart_dma_ready #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .rx_count(rx_count), .rx_hold_full(rx_hold_full), .rx_trigger(rx_trigger),
        .rx_timeout(rx_timeout), .tx_count(tx_count), .tx_hold_full(tx_hold_full),
        .tx_full(tx_full), .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // inputs are already set mid-cycle; advance one edge and compare
    task automatic tick();
        logic  burst;
        logic  rclr;
        logic  tclr;
        logic  have;
        logic  empt;
        string rtag;
        string ttag;
        burst = m_fen & m_sel;
        rclr  = ctrl_wr & ctrl_data[1];
        tclr  = ctrl_wr & ctrl_data[2];
        have  = m_fen ? (rx_count != 0) : rx_hold_full;
        empt  = m_fen ? (tx_count == 0) : !tx_hold_full;
        if (rclr) begin
            e_rx = 1'b1; rtag = "R8";
        end else if (!burst) begin
            e_rx = !have; rtag = (m_sel && !m_fen) ? "R2" : "R3";
        end else if (e_rx) begin
            e_rx = !((rx_count != 0) && ((rx_count >= rx_trigger) || rx_timeout));
            rtag = "R4";
        end else begin
            e_rx = (rx_count == 0); rtag = "R5";
        end
        if (tclr) begin
            e_tx = 1'b0; ttag = "R9";
        end else if (!burst) begin
            e_tx = !empt; ttag = (m_sel && !m_fen) ? "R2" : "R6";
        end else if (!e_tx) begin
            e_tx = tx_full; ttag = "R7";
        end else begin
            e_tx = (tx_count != 0); ttag = "R7";
        end
        @(posedge clk);
        #1;
        if (ctrl_wr) begin
            m_fen = ctrl_data[0];
            m_sel = ctrl_data[3];
        end
        check(rtag, rx_ready_n, e_rx);
        check(ttag, tx_ready_n, e_tx);
    endtask

    task automatic write_ctrl(input logic [3:0] d);
        ctrl_wr = 1'b1;
        ctrl_data = d;
        tick();
        ctrl_wr = 1'b0;
        ctrl_data = '0;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int trig_set[4];
        trig_set[0] = 1; trig_set[1] = 4; trig_set[2] = 8; trig_set[3] = 14;
        // R1: reset values
        #3;
        check("R1", rx_ready_n, 1'b1);
        check("R1", tx_ready_n, 1'b1);
        @(posedge clk); #1;
        check("R1", rx_ready_n, 1'b1);
        check("R1", tx_ready_n, 1'b1);
        rst_n = 1'b1;
        // after reset: FIFOs off, transmit holding empty -> tx request next cycle
        tick();

        for (int mc = 0; mc < 8; mc++) begin
            logic [3:0] cw;
            cw = {mc[1], 2'b00, mc[0]};
            if (mc[2]) cw = cw | 4'b0110;  // combine mode write with clears
            write_ctrl(cw);
            for (int ti = 0; ti < 4; ti++) begin
                for (int to = 0; to < 2; to++) begin
                    rx_trigger = CW'(trig_set[ti]);
                    for (int i = 0; i <= 2 * DEPTH + 2; i++) begin
                        int rc;
                        int tc;
                        rc = (i <= DEPTH) ? i : 2 * DEPTH + 2 - i;
                        if (rc > DEPTH) rc = DEPTH;
                        tc = (i <= DEPTH) ? DEPTH - i : i - DEPTH - 2;
                        if (tc < 0) tc = 0;
                        rx_count = CW'(rc);
                        tx_count = CW'(tc);
                        tx_full = (tc == DEPTH);
                        rx_hold_full = i[1];
                        tx_hold_full = i[2];
                        rx_timeout = (to == 1) && (i == 2);
                        if (i == DEPTH + 5 && to == 1) begin
                            ctrl_wr = 1'b1;
                            ctrl_data = cw | 4'b0110;
                        end
                        tick();
                        ctrl_wr = 1'b0;
                        ctrl_data = '0;
                    end
                    rx_timeout = 1'b0;
                end
            end
        end

        // R4: counts strictly below threshold, no timeout, stay idle
        write_ctrl(4'b1011);
        rx_trigger = CW'(8);
        for (int c = 0; c < 8; c++) begin
            rx_count = CW'(c);
            tick();
            check("R4", rx_ready_n, 1'b1);
        end
        rx_count = CW'(8);
        tick();
        check("R4", rx_ready_n, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule